// File: doc/BRIEF.md
# Staggered CAS-before-RAS DRAM Refresh Controller

This block keeps a four-bank DRAM array refreshed. A prescaled tick input drives an interval counter that raises a refresh request every 15 µs, or, in slow mode, on one interval out of four. Each request runs one CAS-before-RAS cycle. All CAS strobes go low first. The even-bank RAS strobes follow one clock later and the odd-bank RAS strobes one clock after that. After the RAS strobes are released, a precharge window holds the DRAM before another access may use it. A 2-bit speed code sets the RAS active width and the precharge length. The code is sampled when each refresh starts.

The block does not stop the CPU by default. A CPU DRAM access that arrives during a refresh gets a stall indication until the refresh completes. If the hold mode bit is set, a hold request is raised for the whole refresh. A request that arrives while the main DRAM sequencer reports a CPU cycle in progress is stored and starts as soon as the sequencer goes idle. Only one such request is stored.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: With slow mode off, a refresh starts once per INTERVAL_NS/TICK_NS ticks of `tick_i` (15 ticks by default), provided the DRAM is idle.
- R2: With slow mode on, a refresh runs only on every fourth interval, so consecutive refreshes are four intervals apart.
- R3: In a refresh, all four CAS strobes (active low) go low together, exactly one clock before the even-bank RAS strobes. No strobe is low outside a refresh.
- R4: The RAS strobes of banks 1 and 3 fall and rise exactly one clock after those of banks 0 and 2. Banks 0 and 2 always match, and banks 1 and 3 always match.
- R5: The RAS low width per bank depends on the speed code: 2'b11 gives 3 clocks, 2'b10 gives 4, 2'b01 gives 4 and 2'b00 gives 5. CAS stays low from its fall until the odd RAS rises, which is width+2 clocks.
- R6: After the odd RAS rises, the refresh stays active with all strobes high for the precharge length: 3 clocks for codes 2'b11 and 2'b10, 4 for 2'b01 and 5 for 2'b00. So `rfsh_active_o` is high for 2+width+precharge clocks.
- R7: `stall_o` is high exactly in the cycles where `cpu_req_i` is high while a refresh is active. `hold_o` stays low when the hold mode bit is clear.
- R8: When the hold mode bit is set as a refresh starts, `hold_o` is high in every cycle of that refresh and low outside refreshes.
- R9: No refresh starts while `cpu_busy_i` is high. A request that arrives during that time starts a refresh in the clock after `cpu_busy_i` drops. Any number of requests made in that time give only one refresh.
- R10: During reset and after it, every strobe is high and `rfsh_active_o`, `hold_o` and `stall_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaled timing tick, one clock wide, TICK_NS apart |
| speed_i | input | 2 | Speed code: 11 fastest, 10 faster, 01 slower, 00 slowest |
| slow_i | input | 1 | Slow refresh: perform one interval in four |
| hold_mode_i | input | 1 | Raise a hold request for the whole refresh |
| cpu_req_i | input | 1 | CPU DRAM access requested |
| cpu_busy_i | input | 1 | Main DRAM sequencer is running a CPU cycle |
| ras_n_o | output | NUM_BANKS | Per-bank RAS strobe, active low |
| cas_n_o | output | NUM_BANKS | Per-bank CAS strobe, active low |
| rfsh_active_o | output | 1 | A refresh cycle, including its precharge, is in progress |
| hold_o | output | 1 | CPU hold request during refresh (hold mode only) |
| stall_o | output | 1 | The pending CPU access must wait for the refresh |

## Verification
Two events can fall in the same clock: a refresh request and a CPU DRAM cycle, and a CPU access and an active refresh. The bench holds `cpu_busy_i` high across several request intervals and then stops the tick. It then releases the busy signal and expects exactly one refresh, whose CAS falls in the very next cycle. In other phases it keeps `cpu_req_i` asserted while refreshes run and compares `stall_o` cycle by cycle against the refresh window measured at the strobes.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  localparam int PH_W = 4;

  typedef enum logic [1:0] {
    SPD_SLOWEST = 2'b00,
    SPD_SLOWER  = 2'b01,
    SPD_FASTER  = 2'b10,
    SPD_FASTEST = 2'b11
  } speed_e;

  // RAS low width in clocks for each speed grade
  function automatic logic [PH_W-1:0] act_len(input speed_e s);
    case (s)
      SPD_FASTEST: act_len = 4'd3;
      SPD_FASTER:  act_len = 4'd4;
      SPD_SLOWER:  act_len = 4'd4;
      default:     act_len = 4'd5;
    endcase
  endfunction

  // Precharge length in clocks after the last RAS release
  function automatic logic [PH_W-1:0] pre_len(input speed_e s);
    case (s)
      SPD_FASTEST: pre_len = 4'd3;
      SPD_FASTER:  pre_len = 4'd3;
      SPD_SLOWER:  pre_len = 4'd4;
      default:     pre_len = 4'd5;
    endcase
  endfunction

endpackage

// File: rtl/rfsh_pacer.sv
module rfsh_pacer #(
  parameter int TICK_NS     = 1000,
  parameter int INTERVAL_NS = 15000,
  parameter int SLOW_DIV    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic slow_i,
  output logic req_o
);

  localparam int TICKS = INTERVAL_NS / TICK_NS;
  localparam int TW    = $clog2(TICKS + 1);
  localparam int DW    = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [TW-1:0] tick_cnt;
  logic [DW-1:0] div_cnt;
  logic          interval_end;
  logic          div_wrap;

  assign interval_end = tick_i && (tick_cnt == TW'(TICKS - 1));
  assign div_wrap     = (div_cnt == DW'(SLOW_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      div_cnt  <= '0;
      req_o    <= 1'b0;
    end else begin
      req_o <= 1'b0;
      if (tick_i) tick_cnt <= interval_end ? '0 : tick_cnt + 1'b1;
      if (interval_end) begin
        div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
        req_o   <= !slow_i || div_wrap;
      end
    end
  end

  // a request is a single-clock pulse
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o); // R1

endmodule

// File: rtl/rfsh_arbiter.sv
module rfsh_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic cpu_busy_i,
  input  logic rf_busy_i,
  output logic start_o
);

  logic pending;

  assign start_o = pending && !cpu_busy_i && !rf_busy_i;

  // one stored request at most; a new request in the start cycle is kept
  always_ff @(posedge clk) begin
    if (rst)          pending <= 1'b0;
    else if (req_i)   pending <= 1'b1;
    else if (start_o) pending <= 1'b0;
  end

  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (start_o && !req_i) |=> !pending); // R9

endmodule

// File: rtl/rfsh_sequencer.sv
module rfsh_sequencer
  import rfsh_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  speed_e               speed_i,
  input  logic                 hold_mode_i,
  output logic                 busy_o,
  output logic [NUM_BANKS-1:0] ras_n_o,
  output logic [NUM_BANKS-1:0] cas_n_o,
  output logic                 hold_o
);

  localparam int LW = PH_W + 1;

  logic            busy_q, busy_nxt;
  logic [PH_W-1:0] ph_q, ph_nxt;
  logic [PH_W-1:0] act_q, act_nxt, pre_q, pre_nxt;
  logic            hm_q, hm_nxt;
  logic [LW-1:0]   len_q, ph_ext, act_ext;
  logic            cas_on, even_on, odd_on;

  assign len_q = LW'(2) + {1'b0, act_q} + {1'b0, pre_q};

  always_comb begin
    busy_nxt = busy_q;
    ph_nxt   = ph_q;
    act_nxt  = act_q;
    pre_nxt  = pre_q;
    hm_nxt   = hm_q;
    if (start_i) begin
      busy_nxt = 1'b1;
      ph_nxt   = '0;
      act_nxt  = act_len(speed_i);
      pre_nxt  = pre_len(speed_i);
      hm_nxt   = hold_mode_i;
    end else if (busy_q) begin
      if ({1'b0, ph_q} == len_q - 1'b1) begin
        busy_nxt = 1'b0;
        ph_nxt   = '0;
      end else begin
        ph_nxt = ph_q + 1'b1;
      end
    end
  end

  // strobe windows, computed on next-state so outputs come straight from flops
  assign ph_ext  = {1'b0, ph_nxt};
  assign act_ext = {1'b0, act_nxt};
  assign cas_on  = busy_nxt && (ph_ext < act_ext + LW'(2));
  assign even_on = busy_nxt && (ph_ext >= LW'(1)) && (ph_ext < act_ext + LW'(1));
  assign odd_on  = busy_nxt && (ph_ext >= LW'(2)) && (ph_ext < act_ext + LW'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      act_q  <= '0;
      pre_q  <= '0;
      hm_q   <= 1'b0;
      hold_o <= 1'b0;
    end else begin
      busy_q <= busy_nxt;
      ph_q   <= ph_nxt;
      act_q  <= act_nxt;
      pre_q  <= pre_nxt;
      hm_q   <= hm_nxt;
      hold_o <= busy_nxt && hm_nxt;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        ras_n_o[b] <= 1'b1;
        cas_n_o[b] <= 1'b1;
      end else begin
        ras_n_o[b] <= (b % 2 == 1) ? !odd_on : !even_on;
        cas_n_o[b] <= !cas_on;
      end
    end
  end

  assign busy_o = busy_q;

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n_o[0]) |-> ($past(cas_n_o) == '0) && (cas_n_o == '0)); // R3
  AST_ODD_LAGS_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n_o[0]) |=> $fell(ras_n_o[1])); // R4
  AST_ODD_LAGS_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n_o[0]) |=> $rose(ras_n_o[1])); // R4
  AST_STROBE_IN_REFRESH: assert property (@(posedge clk) disable iff (rst)
    ((ras_n_o != '1) || (cas_n_o != '1)) |-> busy_o); // R3
  AST_PRECHARGE_HELD: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n_o[1]) |-> busy_o && (cas_n_o == '1)); // R6
  AST_HOLD_IN_REFRESH: assert property (@(posedge clk) disable iff (rst)
    hold_o |-> busy_o); // R8

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int NUM_BANKS   = 4,
  parameter int TICK_NS     = 1000,
  parameter int INTERVAL_NS = 15000,
  parameter int SLOW_DIV    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic [1:0]           speed_i,
  input  logic                 slow_i,
  input  logic                 hold_mode_i,
  input  logic                 cpu_req_i,
  input  logic                 cpu_busy_i,
  output logic [NUM_BANKS-1:0] ras_n_o,
  output logic [NUM_BANKS-1:0] cas_n_o,
  output logic                 rfsh_active_o,
  output logic                 hold_o,
  output logic                 stall_o
);

  logic req, start, busy;

  rfsh_pacer #(
    .TICK_NS    (TICK_NS),
    .INTERVAL_NS(INTERVAL_NS),
    .SLOW_DIV   (SLOW_DIV)
  ) u_pacer (
    .clk   (clk),
    .rst   (rst),
    .tick_i(tick_i),
    .slow_i(slow_i),
    .req_o (req)
  );

  rfsh_arbiter u_arb (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req),
    .cpu_busy_i(cpu_busy_i),
    .rf_busy_i (busy),
    .start_o   (start)
  );

  rfsh_sequencer #(
    .NUM_BANKS(NUM_BANKS)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .speed_i    (rfsh_pkg::speed_e'(speed_i)),
    .hold_mode_i(hold_mode_i),
    .busy_o     (busy),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .hold_o     (hold_o)
  );

  assign rfsh_active_o = busy;
  assign stall_o       = busy && cpu_req_i;

  AST_NO_START_UNDER_CPU: assert property (@(posedge clk) disable iff (rst)
    $rose(rfsh_active_o) |-> !$past(cpu_busy_i)); // R9
  AST_CAS_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(rfsh_active_o) |-> (cas_n_o == '0) && (ras_n_o == '1)); // R3

endmodule

// File: tb/dram_refresh_ctrl_tb_top.sv
module dram_refresh_ctrl_tb_top;

  localparam int NB       = 4;
  localparam int TICK_DIV = 4;
  localparam int INTV     = 15 * TICK_DIV;

  typedef struct {
    int act;
    int pre;
    int gap;
    bit hold;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_i = 1'b0;
  logic [1:0]    speed_i = 2'b11;
  logic          slow_i = 1'b0;
  logic          hold_mode_i = 1'b0;
  logic          cpu_req_i = 1'b0;
  logic          cpu_busy_i = 1'b0;
  logic [NB-1:0] ras_n_o, cas_n_o;
  logic          rfsh_active_o, hold_o, stall_o;

  int  n_tests = 0, n_fail = 0, cyc = 0, nref = 0, idle_bad = 0;
  bit  tick_en = 1'b0, done = 1'b0;
  exp_t exp_q[$];

  dram_refresh_ctrl #(.NUM_BANKS(NB)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .speed_i(speed_i), .slow_i(slow_i),
    .hold_mode_i(hold_mode_i), .cpu_req_i(cpu_req_i), .cpu_busy_i(cpu_busy_i),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .rfsh_active_o(rfsh_active_o),
    .hold_o(hold_o), .stall_o(stall_o));

  always #2.5 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial begin : ticker
    int t;
    t = 0;
    forever begin
      @(negedge clk);
      t = (t + 1) % TICK_DIV;
      tick_i = tick_en && (t == 0);
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: measure every refresh at the strobes and score against the queue
  int k, ev_w, od_w, cas_w, pre_w, hold_n, stall_bad, lane_bad;
  int i_cas, i_ev, i_od, cur_start, last_start, prev_start;
  bit in_rf = 1'b0;

  task automatic score();
    exp_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R1 unexpected refresh", cur_start, 0);
      return;
    end
    e = exp_q.pop_front();
    check(i_cas == 0, "R3 CAS first low index", i_cas, 0);
    check(i_ev == 1, "R3 even RAS one clock after CAS", i_ev, 1);
    check(i_od == 2, "R4 odd RAS one clock after even", i_od, 2);
    check(lane_bad == 0, "R4 bank pairs mismatched", lane_bad, 0);
    check(ev_w == e.act, "R5 even RAS width", ev_w, e.act);
    check(od_w == e.act, "R5 odd RAS width", od_w, e.act);
    check(cas_w == e.act + 2, "R5 CAS width", cas_w, e.act + 2);
    check(pre_w == e.pre, "R6 precharge length", pre_w, e.pre);
    check(k == 2 + e.act + e.pre, "R6 refresh length", k, 2 + e.act + e.pre);
    check(hold_n == (e.hold ? k : 0), e.hold ? "R8 hold span" : "R7 hold off",
          hold_n, e.hold ? k : 0);
    check(stall_bad == 0, "R7 stall mismatch cycles", stall_bad, 0);
    if (e.gap != 0)
      check(cur_start - prev_start == e.gap, "R1/R2 refresh spacing",
            cur_start - prev_start, e.gap);
  endtask

  initial forever begin
    @(negedge clk);
    if (rst) begin
      in_rf = 1'b0;
    end else if (rfsh_active_o) begin
      if (!in_rf) begin
        in_rf = 1'b1; k = 0; ev_w = 0; od_w = 0; cas_w = 0; pre_w = 0;
        hold_n = 0; stall_bad = 0; lane_bad = 0;
        i_cas = -1; i_ev = -1; i_od = -1; cur_start = cyc;
      end
      if ((cas_n_o != '0 && cas_n_o != '1) || ras_n_o[2] != ras_n_o[0] ||
          ras_n_o[3] != ras_n_o[1]) lane_bad++;
      if (!cas_n_o[0]) begin cas_w++; if (i_cas < 0) i_cas = k; end
      if (!ras_n_o[0]) begin ev_w++;  if (i_ev < 0)  i_ev = k;  end
      if (!ras_n_o[1]) begin od_w++;  if (i_od < 0)  i_od = k;  end
      if (i_od >= 0 && ras_n_o == '1 && cas_n_o == '1) pre_w++;
      if (hold_o) hold_n++;
      if (stall_o != cpu_req_i) stall_bad++;
      k++;
    end else begin
      if (in_rf) begin
        in_rf = 1'b0;
        score();
        prev_start = cur_start;
        last_start = cur_start;
        nref++;
      end
      if (ras_n_o != '1 || cas_n_o != '1 || hold_o || stall_o) idle_bad++;
    end
  end

  task automatic expect_rf(int act, int pre, int gap, bit hold);
    exp_t e;
    e.act = act; e.pre = pre; e.gap = gap; e.hold = hold;
    exp_q.push_back(e);
  endtask

  task automatic wait_nref(int target);
    while (nref < target) @(negedge clk);
  endtask

  task automatic speed_phase(logic [1:0] code, int act, int pre, bit req);
    speed_i = code;
    cpu_req_i = req;
    expect_rf(act, pre, 0, 1'b0);
    expect_rf(act, pre, INTV, 1'b0);
    expect_rf(act, pre, INTV, 1'b0);
    wait_nref(nref + 3);
  endtask

  initial begin : driver
    int base, rel;
    repeat (5) @(negedge clk);
    // R10: reset state
    check(ras_n_o == '1, "R10 RAS idle in reset", int'(ras_n_o), 15);
    check(cas_n_o == '1, "R10 CAS idle in reset", int'(cas_n_o), 15);
    check({rfsh_active_o, hold_o, stall_o} == 3'b000, "R10 status low in reset",
          int'({rfsh_active_o, hold_o, stall_o}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(ras_n_o == '1 && cas_n_o == '1 && !rfsh_active_o, "R10 idle after reset",
          int'({ras_n_o, cas_n_o}), 255);
    tick_en = 1'b1;

    // R1 R5 R6 R7: each speed grade, stall exercised on two of them
    speed_phase(2'b11, 3, 3, 1'b0);
    speed_phase(2'b10, 4, 3, 1'b1);
    speed_phase(2'b01, 4, 4, 1'b0);
    speed_phase(2'b00, 5, 5, 1'b1);

    // R8: hold mode
    speed_i = 2'b11; cpu_req_i = 1'b0; hold_mode_i = 1'b1;
    expect_rf(3, 3, 0, 1'b1);
    expect_rf(3, 3, INTV, 1'b1);
    wait_nref(nref + 2);
    hold_mode_i = 1'b0;

    // R2: slow refresh
    slow_i = 1'b1;
    expect_rf(3, 3, 0, 1'b0);
    expect_rf(3, 3, 4 * INTV, 1'b0);
    expect_rf(3, 3, 4 * INTV, 1'b0);
    wait_nref(nref + 3);
    slow_i = 1'b0;

    // R9: deferral behind a CPU cycle, single stored request
    cpu_busy_i = 1'b1;
    base = nref;
    repeat (4 * INTV) @(negedge clk);
    check(nref == base, "R9 no refresh while CPU busy", nref - base, 0);
    tick_en = 1'b0;
    repeat (2 * TICK_DIV) @(negedge clk);
    expect_rf(3, 3, 0, 1'b0);
    rel = cyc;
    cpu_busy_i = 1'b0;
    repeat (40) @(negedge clk);
    check(nref == base + 1, "R9 one refresh after release", nref - base, 1);
    check(last_start == rel + 1, "R9 start right after release", last_start, rel + 1);

    check(exp_q.size() == 0, "R1 expected refreshes seen", exp_q.size(), 0);
    check(idle_bad == 0, "R3 strobes quiet outside refresh", idle_bad, 0);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule